// File: doc/BRIEF.md
# Busy Status Polling Responder

This block sits between the read path of a flash array and the host while the array is running an internally timed program or erase. A start pulse opens a busy window. The window lasts a fixed number of clock cycles, and each operation type has its own parameterised length. While the window is open, every read strobe returns a status byte instead of array contents.

The status byte carries two completion indicators that do not depend on each other. The polling bit, the top bit, holds the complement of the top bit of the byte being programmed. During an erase it holds 0, because the erased value is 1. The toggle bit, the next bit down, flips on each busy read. Once the window closes, reads pass the array data through unchanged, and the block can accept a new start at once.

Command decoding and array storage sit outside this block. A neighbour decodes commands and raises the start pulse. The same neighbour drives the array data and the top bit of the programmed byte.

Top module: `busy_poll_responder`

## Requirements
- R1: While reset is low and after it is released, busy_o and done_o are 0 and rdata_o is all zeros.
- R2: A start accepted at a clock edge makes busy_o high from that edge. With op_erase_i = 0 (program), busy_o stays high for exactly PROG_CYCLES cycles.
- R3: With op_erase_i = 1 (erase), busy_o stays high for exactly ERASE_CYCLES cycles.
- R4: done_o is high for exactly one cycle. It rises at the same edge where busy_o falls at the end of a completed operation.
- R5: A read strobe during a program returns the inverse of the latched msb_i on bit DATA_W-1. Bits DATA_W-3 down to 0 read 0.
- R6: A read strobe during an erase returns 0 on bit DATA_W-1.
- R7: Successive read strobes while busy return alternating values on bit DATA_W-2.
- R8: A read strobe while not busy returns array_data_i on all bits.
- R9: A start raised while busy_o is high is ignored. The remaining duration and the latched polling value are unchanged.
- R10: A start raised in the cycle where done_o is high is accepted, so busy_o is high at the next edge.
- R11: A low rst_ni drops busy_o at once, without waiting for a clock edge. The aborted operation never raises done_o, and the next read returns array data.
- R12: The first read strobe in the cycle right after a start returns status, not array data.
- R13: rdata_o holds its value in cycles without a read strobe, even when array_data_i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; aborts any operation |
| start_i | input | 1 | One-cycle request to begin a timed operation |
| op_erase_i | input | 1 | Operation type for start_i: 0 program, 1 erase |
| msb_i | input | 1 | Top bit of the byte being programmed, latched with start_i |
| rd_i | input | 1 | Read strobe |
| array_data_i | input | DATA_W | True array contents at the read address |
| rdata_o | output | DATA_W | Registered read result (status or array data) |
| busy_o | output | 1 | High while an operation is timing |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The block reacts one edge after each stimulus. busy_o rises at the edge that samples start_i, and rdata_o changes at the edge that samples rd_i. done_o rises at the same edge where busy_o falls, after the final cycle of the count. The bench drives inputs and samples outputs only at falling edges. This means every result is read half a cycle after the rising edge that produced it, so durations are counted in whole falling-edge samples. The toggle bit is checked only for alternation between consecutive busy reads, because its starting value has no meaning to the host.

// File: rtl/poll_resp_pkg.sv
package poll_resp_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/busy_timer.sv
module busy_timer
  import poll_resp_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 12,
  parameter int unsigned ERASE_CYCLES = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned MAX_DUR = max_u(PROG_CYCLES, ERASE_CYCLES);
  localparam int unsigned CNT_W   = $clog2(MAX_DUR + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  // starts during an active operation are dropped
  assign accept_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= (op_i == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_busy_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CNT_W'(MAX_DUR)));
  p_done_on_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == '0) |=> (done_q && !busy_q));
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_ignore_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/poll_responder.sv
module poll_responder
  import poll_resp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  op_e               op_i,
  input  logic              msb_i,
  input  logic              busy_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TOG_BIT  = DATA_W - 2;

  logic              poll_q, tog_q;
  logic [DATA_W-1:0] rdata_q, stat;

  always_comb begin
    stat           = '0;
    stat[POLL_BIT] = poll_q;
    stat[TOG_BIT]  = ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q  <= 1'b0;
      tog_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept_i) poll_q <= (op_i == OP_ERASE) ? 1'b0 : ~msb_i;
      if (rd_i) begin
        if (busy_i) begin
          tog_q   <= ~tog_q;
          rdata_q <= stat;
        end else begin
          rdata_q <= array_i;
        end
      end
    end
  end

  assign rdata_o = rdata_q;

  p_poll_prog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && op_i == OP_PROG |=> poll_q == !$past(msb_i));
  p_poll_erase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && op_i == OP_ERASE |=> !poll_q);
  p_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i) |=> rdata_o[TOG_BIT] != $past(tog_q));
  p_true_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !busy_i) |=> rdata_o == $past(array_i));
  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/busy_poll_responder.sv
module busy_poll_responder
  import poll_resp_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PROG_CYCLES  = 12,
  parameter int unsigned ERASE_CYCLES = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic              msb_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o
);
  op_e  op;
  logic accept;

  assign op = op_erase_i ? OP_ERASE : OP_PROG;

  busy_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op),
    .accept_o(accept),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  poll_responder #(
    .DATA_W(DATA_W)
  ) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .op_i    (op),
    .msb_i   (msb_i),
    .busy_i  (busy_o),
    .rd_i    (rd_i),
    .array_i (array_data_i),
    .rdata_o (rdata_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && rdata_o == '0));
  p_rst_no_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !done_o);
endmodule

// File: tb/tb_busy_poll_responder.sv
module tb_busy_poll_responder;
  localparam int DW = 8;
  localparam int PC = 12;
  localparam int EC = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, op_erase_i = 1'b0, msb_i = 1'b0, rd_i = 1'b0;
  logic [DW-1:0] array_data_i = '0;
  logic [DW-1:0] rdata_o;
  logic busy_o, done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  busy_poll_responder #(.DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_erase_i(op_erase_i),
    .msb_i(msb_i), .rd_i(rd_i), .array_data_i(array_data_i),
    .rdata_o(rdata_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic erase, input logic msb);
    start_i = 1'b1; op_erase_i = erase; msb_i = msb;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_read(output logic [DW-1:0] v);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    v = rdata_o;
  endtask

  // counts falling-edge samples with busy high, stops on first low sample
  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(busy_o == 0 && done_o == 0 && rdata_o == 0, "R1 reset", {busy_o, done_o, rdata_o}, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && rdata_o == 0, "R1 after release", {busy_o, done_o, rdata_o}, 0);
  endtask

  task automatic t_program_len;
    int n;
    launch(1'b0, 1'b1);
    chk(busy_o == 1, "R2 busy after start", busy_o, 1);
    count_busy(n);
    chk(n == PC, "R2 program duration", n, PC);
    chk(done_o == 1, "R4 done at busy fall", done_o, 1);
    @(negedge clk);
    chk(done_o == 0, "R4 done single cycle", done_o, 0);
  endtask

  task automatic t_poll_program(input logic msb);
    logic [DW-1:0] v0, v1, v2, v3;
    launch(1'b0, msb);
    array_data_i = 8'h5A;
    do_read(v0); do_read(v1); do_read(v2);
    chk(v0[7] == !msb, "R12 R5 first read is status", v0, {!msb, 7'h0});
    chk(v0[5:0] == 0 && v1[5:0] == 0, "R5 low status bits zero", {v0[5:0], v1[5:0]}, 0);
    chk(v1[7] == !msb && v2[7] == !msb, "R5 poll bit steady", {v1[7], v2[7]}, {!msb, !msb});
    chk(v1[6] != v0[6] && v2[6] != v1[6], "R7 toggle alternates", {v0[6], v1[6], v2[6]}, 0);
    while (busy_o) @(negedge clk);
    do_read(v3);
    chk(v3 == 8'h5A, "R8 true data after done", v3, 8'h5A);
  endtask

  task automatic t_erase;
    logic [DW-1:0] v0, v1;
    int n;
    launch(1'b1, 1'b0);
    do_read(v0); do_read(v1);
    chk(v0[7] == 0 && v1[7] == 0, "R6 erase poll bit", {v0[7], v1[7]}, 0);
    chk(v0[6] != v1[6], "R7 toggle during erase", {v0[6], v1[6]}, 0);
    count_busy(n);
    chk(n == EC - 2, "R3 erase duration", n + 2, EC);
    chk(done_o == 1, "R4 erase done", done_o, 1);
  endtask

  task automatic t_ignore;
    logic [DW-1:0] v;
    int n;
    launch(1'b0, 1'b1);
    start_i = 1'b1; op_erase_i = 1'b1; msb_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    do_read(v);
    chk(v[7] == 0, "R9 poll bit unchanged", v[7], 0);
    count_busy(n);
    chk(n == PC - 2, "R9 duration unchanged", n + 2, PC);
  endtask

  task automatic t_back2back;
    int n;
    launch(1'b0, 1'b0);
    count_busy(n);
    chk(done_o == 1, "R10 done before restart", done_o, 1);
    launch(1'b1, 1'b0);
    chk(busy_o == 1, "R10 restart in done cycle", busy_o, 1);
    count_busy(n);
    chk(n == EC, "R10 R3 restarted erase duration", n, EC);
  endtask

  task automatic t_reset_mid;
    logic [DW-1:0] v;
    bit seen = 0;
    launch(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    #2 rst_ni = 1'b0;
    #1;
    chk(busy_o == 0, "R11 async busy drop", busy_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < PC + 3; i++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
    chk(!seen, "R11 no done after abort", seen, 0);
    array_data_i = 8'hC3;
    do_read(v);
    chk(v == 8'hC3, "R11 read after abort is data", v, 8'hC3);
  endtask

  task automatic t_hold;
    logic [DW-1:0] v;
    array_data_i = 8'h81;
    do_read(v);
    array_data_i = 8'h7E;
    repeat (3) @(negedge clk);
    chk(rdata_o == 8'h81, "R13 hold without strobe", rdata_o, 8'h81);
    do_read(v);
    chk(v == 8'h7E, "R8 R13 new strobe samples", v, 8'h7E);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_program_len();
    t_poll_program(1'b1);
    t_poll_program(1'b0);
    t_erase();
    t_ignore();
    t_back2back();
    t_reset_mid();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule